// File: doc/BRIEF.md
# Memory Controller with Check Bits and Per-Task Error Log

This block fronts a small word-addressed memory of 16-bit data words for a microcoded processor. Next to each data word it keeps a 6-bit check field, built from parity over selected data bits. It compares that field again whenever a word is fetched. The processor reaches the block through four operations:

- loading the address register;
- writing a data word at that address;
- reading the data latch, tagged with the number of the task that reads;
- writing a control word.

Loading the address fetches the word at once into a data latch. Reads return the latch contents. When a read finds the latched word invalid, it records the failure in a status word. That status word has one error bit for each of eight tasks plus a shared error flag. A control write can clear the bit of one task. A control write also sets a mask that inverts chosen check bits on all later writes. Software uses this to corrupt stored check fields on purpose and test the detection path.

Top module: `memctl_errlog`

## Requirements
- R1: After reset the status word is zero, the address register is zero, the read data is zero with the valid flag high, and every implemented word reads back as zero and valid.
- R2: A rising edge with `addr_ld` high loads `addr_in` into the address register. At the same edge it captures the word at `addr_in` and that word's validity into the data latch. Both appear on `rd_data` and `rd_valid` from the next cycle on.
- R3: A rising edge with `wr_en` high stores `wr_data` at the current address register, using its value before that edge. The data latch changes only on an address load, so a write never alters `rd_data`. This holds even for a write to the address just loaded.
- R4: A control write loads `ctl_data[7:2]` as a 6-bit inversion mask. Each later write XORs its stored check field with that mask. A word written with a nonzero mask reads back invalid. A word written with a zero mask reads back valid.
- R5: A control write with `ctl_data[11]` set clears status bit (7 − `ctl_data[10:8]`). With bit 11 clear, the status word is not touched.
- R6: A read (`rd_en`) while the latch is invalid sets status bit (7 − `rd_task`) and status bit 8 at that edge.
- R7: A read while the latch is valid clears status bits 8 and 9 and leaves status bits 7:0 unchanged.
- R8: Loading an address at or above `DEPTH` gives `rd_data` zero and `rd_valid` low.
- R9: A write while the address register is at or above `DEPTH` changes no memory word.
- R10: When an invalid read and a control clear name the same task in the same cycle, that task's error bit ends up set.
- R11: Status bits 15:9 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_ld | input | 1 | Load address register and prefetch word |
| addr_in | input | AW | Address to load |
| wr_en | input | 1 | Write data at current address |
| wr_data | input | 16 | Data to write |
| rd_en | input | 1 | Read strobe; logs the latch validity |
| rd_task | input | 3 | Number of the reading task |
| rd_data | output | 16 | Latched data word |
| rd_valid | output | 1 | Latched validity |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_data | input | 16 | Control word: [7:2] mask, [11] clear, [10:8] task |
| status | output | 16 | Error log: [7-t] task t, [8] shared error |
| addr_q | output | AW | Current address register |

## Verification
The hardest case to reach from the ports is an invalid read and a control clear that hit the same task in the same edge. Reaching it needs a latch that is already invalid, so the address must be loaded first, either to a word written under a nonzero mask or to an address out of range. The strobes and the control word must then line up in one cycle. A directed sequence builds that state on purpose. After it, seeded random traffic mixes masks, address loads into and beyond the array, reads from random tasks and clears.

// File: rtl/memctl_errlog.sv
module memctl_errlog #(
  parameter int DEPTH = 64,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  input  logic          rd_en,
  input  logic [2:0]    rd_task,
  output logic [15:0]   rd_data,
  output logic          rd_valid,
  input  logic          ctl_wr,
  input  logic [15:0]   ctl_data,
  output logic [15:0]   status,
  output logic [AW-1:0] addr_q
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  function automatic logic [5:0] chk(input logic [15:0] d);
    logic [5:0] c;
    c = '0;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 16; j++)
        if ((((j + 1) >> i) & 1) == 1) c[i] = c[i] ^ d[j];
    c[5] = ^d;
    return c;
  endfunction

  logic [15:0] mem_d [DEPTH];
  logic [5:0]  mem_c [DEPTH];
  logic [5:0]  inv_mask;
  logic [15:0] lat_d;
  logic        lat_ok;
  logic [8:0]  stat_q, stat_n;

  wire          ld_hit  = {1'b0, addr_in} < LIMIT;
  wire          wr_hit  = {1'b0, addr_q} < LIMIT;
  wire [IW-1:0] ld_idx  = addr_in[IW-1:0];
  wire [IW-1:0] wr_idx  = addr_q[IW-1:0];
  wire [15:0]   fetch_d = ld_hit ? mem_d[ld_idx] : 16'h0;
  wire          fetch_ok = ld_hit && (mem_c[ld_idx] == chk(mem_d[ld_idx]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        mem_d[k] <= '0;
        mem_c[k] <= '0;
      end
    end else if (wr_en && wr_hit) begin
      mem_d[wr_idx] <= wr_data;
      mem_c[wr_idx] <= chk(wr_data) ^ inv_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lat_d  <= '0;
      lat_ok <= 1'b1;
    end else if (addr_ld) begin
      addr_q <= addr_in;
      lat_d  <= fetch_d;
      lat_ok <= fetch_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      inv_mask <= '0;
    else if (ctl_wr) inv_mask <= ctl_data[7:2];
  end

  always_comb begin
    stat_n = stat_q;
    if (ctl_wr && ctl_data[11]) stat_n[3'd7 - ctl_data[10:8]] = 1'b0;
    if (rd_en) begin
      if (!lat_ok) begin
        stat_n[3'd7 - rd_task] = 1'b1;
        stat_n[8] = 1'b1;
      end else begin
        stat_n[8] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_n;
  end

  assign rd_data  = lat_d;
  assign rd_valid = lat_ok;
  assign status   = {7'b0, stat_q};
endmodule

module memctl_errlog_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_ld,
  input logic          rd_en,
  input logic [2:0]    rd_task,
  input logic [15:0]   rd_data,
  input logic          rd_valid,
  input logic          ctl_wr,
  input logic [15:0]   ctl_data,
  input logic [15:0]   status,
  input logic [AW-1:0] addr_q
);
  wire bad_rd = rd_en && !rd_valid;

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[15:9] == 7'h0); // R11
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rd |=> status[8] && status[3'd7 - $past(rd_task)]); // R6
  AST_OK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_valid |=> !status[8]); // R7
  AST_TASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_valid && !ctl_wr |=> status[7:0] == $past(status[7:0])); // R7
  AST_CLR_TASK: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_data[11] && !bad_rd |=> !status[3'd7 - $past(ctl_data[10:8])]); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rd && ctl_wr && ctl_data[11] && ctl_data[10:8] == rd_task |=> status[3'd7 - $past(rd_task)]); // R10
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, addr_q} >= (AW+1)'(DEPTH)) |-> rd_data == 16'h0 && !rd_valid); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ld |=> $stable(rd_data) && $stable(rd_valid)); // R3
endmodule

bind memctl_errlog memctl_errlog_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .rd_en(rd_en), .rd_task(rd_task),
  .rd_data(rd_data), .rd_valid(rd_valid), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
  .status(status), .addr_q(addr_q)
);

// File: tb/sim_memctl_errlog.sv
module sim_memctl_errlog;
  localparam int DEPTH = 64;
  localparam int AW    = 8;
  localparam int TCLK  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_ld = 0, wr_en = 0, rd_en = 0, ctl_wr = 0;
  logic [AW-1:0] addr_in = '0;
  logic [15:0] wr_data = '0, ctl_data = '0;
  logic [2:0] rd_task = '0;
  logic [15:0] rd_data, status;
  logic rd_valid;
  logic [AW-1:0] addr_q;

  int checks = 0, fails = 0, cyc = 0;

  memctl_errlog #(.DEPTH(DEPTH), .AW(AW)) u0 (.*);

  always #(TCLK/2) clk = ~clk;

  logic [15:0] m_d [DEPTH];
  logic        m_bad [DEPTH];
  logic [AW-1:0] e_addr;
  logic [15:0] e_dat, e_stat;
  logic e_ok;
  logic [5:0] e_mask;

  function automatic logic in_rng(input logic [AW-1:0] a);
    return int'(a) < DEPTH;
  endfunction

  function automatic logic [15:0] next_stat(input logic [15:0] s);
    logic [15:0] n = s;
    if (ctl_wr && ctl_data[11]) n[7 - int'(ctl_data[10:8])] = 1'b0;
    if (rd_en) begin
      if (!e_ok) begin n[7 - int'(rd_task)] = 1'b1; n[8] = 1'b1; end
      else n[9:8] = 2'b00;
    end
    return n;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " rd_data"}, 32'(rd_data), 32'(e_dat));
    cmp({tag, " rd_valid"}, 32'(rd_valid), 32'(e_ok));
    cmp({tag, " status"}, 32'(status), 32'(e_stat));
    cmp({tag, " addr_q R2"}, 32'(addr_q), 32'(e_addr));
    cmp("R11 status high bits", 32'(status[15:9]), 32'h0);
  endtask

  task automatic step(input string tag);
    logic [AW-1:0] a_old;
    @(posedge clk);
    cyc++;
    a_old = e_addr;
    e_stat = next_stat(e_stat);
    if (addr_ld) begin
      e_addr = addr_in;
      e_dat  = in_rng(addr_in) ? m_d[int'(addr_in)] : 16'h0;
      e_ok   = in_rng(addr_in) && !m_bad[int'(addr_in)];
    end
    if (wr_en && in_rng(a_old)) begin
      m_d[int'(a_old)] = wr_data;
      m_bad[int'(a_old)] = (e_mask != 0);
    end
    if (ctl_wr) e_mask = ctl_data[7:2];
    @(negedge clk);
    check_all(tag);
    addr_ld = 0; wr_en = 0; rd_en = 0; ctl_wr = 0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input string tag);
    addr_ld = 1; addr_in = a; step(tag);
  endtask
  task automatic do_write(input logic [15:0] d, input string tag);
    wr_en = 1; wr_data = d; step(tag);
  endtask
  task automatic do_read(input logic [2:0] t, input string tag);
    rd_en = 1; rd_task = t; step(tag);
  endtask
  task automatic do_ctl(input logic [15:0] c, input string tag);
    ctl_wr = 1; ctl_data = c; step(tag);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < DEPTH; k++) begin m_d[k] = 0; m_bad[k] = 0; end
    e_addr = 0; e_dat = 0; e_ok = 1; e_stat = 0; e_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset state");
    for (int k = 0; k < DEPTH; k += 9) do_load(AW'(k), "R1 cleared word");

    do_load(8'd5, "R2 load 5");
    do_write(16'hBEEF, "R3 write keeps latch");
    addr_ld = 1; addr_in = 8'd5; wr_en = 1; wr_data = 16'h7777;
    step("R3 load and write same cycle");
    do_load(8'd5, "R2 prefetch new word");
    do_ctl(16'h0004, "R4 set mask");
    do_write(16'h1234, "R4 write with mask");
    do_load(8'd5, "R4 masked word invalid");
    do_read(3'd2, "R6 invalid read task 2");
    do_read(3'd6, "R6 invalid read task 6");
    do_ctl(16'h0000, "R5 no clear without bit 11");
    do_ctl(16'h0A00, "R5 clear task 2");
    do_load(8'd9, "R2 load 9");
    do_write(16'h4321, "R4 unmasked write");
    do_load(8'd9, "R4 unmasked valid");
    do_read(3'd0, "R7 valid read clears bit 8");
    do_load(8'd70, "R8 out of range load");
    do_write(16'h5555, "R9 out of range write");
    do_load(8'd6, "R9 alias untouched");
    do_load(8'd200, "R8 far out of range");
    rd_en = 1; rd_task = 3'd4; ctl_wr = 1; ctl_data = 16'h0C00;
    step("R10 set beats clear");
    do_read(3'd4, "R6 repeat read");

    for (int n = 0; n < 4000; n++) begin
      int op = int'($urandom_range(0, 9));
      if (op <= 2) begin
        addr_ld = 1;
        addr_in = ($urandom_range(0, 7) == 0) ? AW'($urandom_range(DEPTH, 255))
                                              : AW'($urandom_range(0, DEPTH-1));
      end
      if (op >= 2 && op <= 4) begin wr_en = 1; wr_data = 16'($urandom); end
      if (op >= 4 && op <= 7) begin rd_en = 1; rd_task = 3'($urandom); end
      if (op >= 7) begin
        ctl_wr = 1;
        ctl_data = 16'($urandom) & 16'h0F00;
        if ($urandom_range(0, 3) == 0) ctl_data[7:2] = 6'($urandom);
      end
      step("R6/R7 random");
    end
    finish_run();
  end
endmodule